// File: doc/BRIEF.md
# UART Receive Status Flag Unit

This block sits between the bit-level receive shifter of a UART and the register interface a processor reads. When the shifter signals that a byte is complete, the unit either loads the byte into a holding register and raises a data-ready flag, or discards the byte and raises an overrun flag because the previous byte has not been collected. A noise indication and the sampled stop bit come with each byte. They are latched into a noise flag and a framing-error flag together with the byte they accompany.

Software clears the flags with a two-step sequence. First it reads the status register, which records ("arms") each flag that is set at that moment. Then it reads the data register, which clears only the armed flags and disarms them all. A flag that rises between the two reads is not armed, so it survives the sequence. A second status read then shows that a byte was lost. An error interrupt request is raised for the noise and framing flags when their individual enables are set.

Top module: `uart_rx_status_unit`

## Requirements
- R1: Status bit positions are: bit 0 data-ready, bit 1 overrun, bit 2 noise, bit 3 framing error. A completed byte that arrives while data-ready is clear is loaded into `data_out` one cycle after the strobe, and data-ready sets.
- R2: A completed byte that arrives while data-ready is set, and is not taken by a same-cycle clearing data read, sets overrun and is dropped, so `data_out` keeps the earlier byte.
- R3: A flag clears only when a data read follows a status read that saw that flag set. A data read without such a preceding status read clears nothing.
- R4: A flag that becomes set after the status read and before the data read is not cleared by that data read, and it shows on the next status read.
- R5: The noise flag sets when an accepted byte comes with the noise indication. A dropped byte's noise indication has no effect.
- R6: The framing flag sets when an accepted byte arrives with a stop-bit value of 0.
- R7: `err_irq` is high when the noise flag and `noise_ie` are both set, or when the framing flag and `frame_ie` are both set; otherwise it is low.
- R8: When a byte completes in the same cycle as a data read that clears an armed data-ready, the new byte is loaded, data-ready stays set and overrun does not set.
- R9: Reset clears all four flags, all armed bits and `data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | 1 | One-cycle strobe: a byte has been shifted in |
| rx_byte | input | DATA_W | Byte accompanying `rx_done` |
| rx_noise | input | 1 | Noise was seen while receiving this byte |
| rx_stop | input | 1 | Sampled stop-bit value for this byte |
| stat_rd | input | 1 | Processor read strobe of the status register |
| data_rd | input | 1 | Processor read strobe of the data register |
| noise_ie | input | 1 | Enable of the noise error interrupt |
| frame_ie | input | 1 | Enable of the framing error interrupt |
| status | output | 4 | Flags: {framing, noise, overrun, data-ready} |
| data_out | output | DATA_W | Data holding register |
| err_irq | output | 1 | Error interrupt request |

## Verification
The assertions check these rules on every cycle: a flag never falls unless a clear request from the arm latch was present, a same-cycle set always leaves the flag high, the holding register never changes without a load, overrun and data-ready rise only after a byte strobe, and a data read leaves every flag disarmed. The interrupt mask is also checked each cycle. Some behaviours appear only as ordered sequences of reads and strobes, so only the bench scenarios can show them. These are the delayed clearing sequence in which the lost byte is identified, the next read returning the byte after the lost one, the flags surviving a data read that has no status read before it, and the same-cycle load that replaces a byte being read.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int NFLAG = 4;
   localparam int F_RDY = 0;
   localparam int F_OVR = 1;
   localparam int F_NSE = 2;
   localparam int F_FRM = 3;
   typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   // R3
   clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/rxs_arm_latch.sv
module rxs_arm_latch
   import rxs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stat_rd,
   input  logic      data_rd,
   input  flag_vec_t flags_i,
   output flag_vec_t clr_o
);
   flag_vec_t armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed <= '0;
      else if (stat_rd) armed <= flags_i;
      else if (data_rd) armed <= '0;
   end

   assign clr_o = data_rd ? armed : '0;

   // R3
   disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !stat_rd) |=> (armed == '0));
   // R4
   late_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !flags_i[F_OVR]) |=> !clr_o[F_OVR]);
endmodule

// File: rtl/rxs_data_hold.sv
module rxs_data_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dout <= '0;
      else if (load_i) dout <= din;
   end

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(dout));
endmodule

// File: rtl/rxs_irq_gate.sv
module rxs_irq_gate #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic noise_f,
   input  logic frame_f,
   input  logic noise_ie,
   input  logic frame_ie,
   output logic irq_o
);
   logic req;
   assign req = (noise_f & noise_ie) | (frame_f & frame_ie);

   if (IRQ_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= 1'b0;
         else        irq_o <= req;
      end
   end else begin : g_comb
      assign irq_o = req;
      // R7
      irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!noise_ie && !frame_ie) |-> !irq_o);
   end
endmodule

// File: rtl/uart_rx_status_unit.sv
module uart_rx_status_unit
   import rxs_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_noise,
   input  logic              rx_stop,
   input  logic              stat_rd,
   input  logic              data_rd,
   input  logic              noise_ie,
   input  logic              frame_ie,
   output logic [NFLAG-1:0]  status,
   output logic [DATA_W-1:0] data_out,
   output logic              err_irq
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("uart_rx_status_unit: DATA_W must lie in 1..32");
   end

   flag_vec_t flags, clr, set;
   logic      take, accept, drop;

   rxs_arm_latch u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .stat_rd (stat_rd),
      .data_rd (data_rd),
      .flags_i (flags),
      .clr_o   (clr)
   );

   assign take   = clr[F_RDY];
   assign accept = rx_done & (~flags[F_RDY] | take);
   assign drop   = rx_done & flags[F_RDY] & ~take;

   always_comb begin
      set        = '0;
      set[F_RDY] = accept;
      set[F_OVR] = drop;
      set[F_NSE] = accept & rx_noise;
      set[F_FRM] = accept & ~rx_stop;
   end

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      rxs_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set[i]),
         .clr_i  (clr[i]),
         .flag_o (flags[i])
      );
   end

   rxs_data_hold #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .din    (rx_byte),
      .dout   (data_out)
   );

   rxs_irq_gate #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .noise_f  (flags[F_NSE]),
      .frame_f  (flags[F_FRM]),
      .noise_ie (noise_ie),
      .frame_ie (frame_ie),
      .irq_o    (err_irq)
   );

   assign status = flags;

   // R2
   ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[F_OVR]) |-> $past(rx_done));
   // R1
   rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[F_RDY]) |-> $past(rx_done));
endmodule

// File: tb/uart_rx_status_unit_test.sv
`timescale 1ns/1ps
module uart_rx_status_unit_test;
   logic       clk = 0, rst_n = 0;
   logic       rx_done = 0, rx_noise = 0, rx_stop = 1;
   logic [7:0] rx_byte = 0;
   logic       stat_rd = 0, data_rd = 0, noise_ie = 0, frame_ie = 0;
   logic [3:0] status;
   logic [7:0] data_out;
   logic       err_irq;
   int checks = 0, bad = 0;
   bit finished = 0;
   logic [7:0] sb_q[$];

   always #2.5 clk = ~clk;

   uart_rx_status_unit uut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
      .rx_noise(rx_noise), .rx_stop(rx_stop), .stat_rd(stat_rd),
      .data_rd(data_rd), .noise_ie(noise_ie), .frame_ie(frame_ie),
      .status(status), .data_out(data_out), .err_irq(err_irq));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: pushes expected bytes into the scoreboard
   task automatic send(logic [7:0] b, logic nse, logic stp, bit accepted);
      @(negedge clk);
      rx_done = 1; rx_byte = b; rx_noise = nse; rx_stop = stp;
      @(negedge clk);
      rx_done = 0; rx_noise = 0; rx_stop = 1;
      if (accepted) sb_q.push_back(b);
   endtask

   task automatic rd_stat(output logic [3:0] s);
      @(negedge clk);
      stat_rd = 1; s = status;
      @(negedge clk);
      stat_rd = 0;
   endtask

   // monitor: pops and compares the byte returned by a data read
   task automatic rd_data(string tag, bit pop);
      logic [7:0] e;
      @(negedge clk);
      data_rd = 1;
      if (pop) begin
         e = sb_q.pop_front();
         chk(tag, data_out, e);
      end
      @(negedge clk);
      data_rd = 0;
   endtask

   initial begin
      #(100000 * 5);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", checks + 1, bad);
         $finish;
      end
   end

   initial begin
      logic [3:0] s;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 status", status, 4'h0);
      chk("R9 data", data_out, 8'h00);
      chk("R9 irq", err_irq, 1'b0);
      rst_n = 1;
      @(negedge clk);

      // R1 clean byte and normal clearing
      send(8'hA5, 0, 1, 1);
      chk("R1 status", status, 4'h1);
      rd_stat(s);
      chk("R1 seen", s, 4'h1);
      rd_data("R1 data", 1);
      chk("R3 cleared", status, 4'h0);

      // R2/R4 delayed sequence: lost byte identified
      send(8'hB1, 0, 1, 1);
      rd_stat(s);
      send(8'hB2, 0, 1, 0);
      chk("R2 kept", data_out, 8'hB1);
      rd_data("R2 data", 1);
      chk("R4 ovr survives", status, 4'h2);
      rd_stat(s);
      chk("R4 second read", s, 4'h2);
      send(8'hB3, 0, 1, 1);
      chk("R2 next", status, 4'h3);
      rd_stat(s);
      rd_data("R2 byte after lost", 1);
      chk("R3 all clear", status, 4'h0);

      // R3 data read without status read clears nothing
      send(8'hC7, 0, 1, 1);
      rd_data("R3 noarm", 0);
      chk("R3 noarm status", status, 4'h1);
      rd_stat(s);
      rd_data("R3 data", 1);

      // R5/R7 noise
      send(8'h5A, 1, 1, 1);
      chk("R5 noise", status, 4'h5);
      chk("R7 masked", err_irq, 1'b0);
      noise_ie = 1;
      #1 chk("R7 noise irq", err_irq, 1'b1);
      // R5 dropped byte's noise ignored
      rd_stat(s);
      rd_data("R5 data", 1);
      send(8'h11, 0, 1, 1);
      send(8'h22, 1, 1, 0);
      chk("R5 drop noise", status, 4'h3);
      chk("R5 drop irq", err_irq, 1'b0);
      rd_stat(s);
      rd_data("R5 data2", 1);
      noise_ie = 0;

      // R6/R7 framing
      send(8'h3C, 0, 0, 1);
      chk("R6 frame", status, 4'h9);
      chk("R7 frame masked", err_irq, 1'b0);
      frame_ie = 1;
      #1 chk("R7 frame irq", err_irq, 1'b1);
      rd_stat(s);
      rd_data("R6 data", 1);
      chk("R6 cleared", status, 4'h0);
      frame_ie = 0;

      // R8 set beats clear in the same cycle
      send(8'hD1, 0, 1, 1);
      rd_stat(s);
      @(negedge clk);
      data_rd = 1; rx_done = 1; rx_byte = 8'hD2;
      chk("R8 read old", data_out, sb_q.pop_front());
      @(negedge clk);
      data_rd = 0; rx_done = 0;
      sb_q.push_back(8'hD2);
      chk("R8 status", status, 4'h1);
      chk("R8 data", data_out, 8'hD2);
      rd_stat(s);
      rd_data("R8 data read", 1);
      chk("R8 cleared", status, 4'h0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule